// File: doc/BRIEF.md
# Dithered-Edge PWM Tuning DAC

This block turns a wide digital tuning word into a single-bit pulse-width waveform that, after external low-pass filtering, steers the control voltage of a reference oscillator. The block runs on the oscillator's own clock. A free-running counter divides that clock into fixed frames of 2^CNT_WIDTH cycles, which is 1024 cycles by default. Each frame starts high and goes low once. The upper CNT_WIDTH bits of the command set how many whole clocks the pulse stays high.

The low LSB_WIDTH bits of the command add resolution below one clock. In a share of frames equal to the low value divided by 2^LSB_WIDTH, the falling edge comes one clock later. The frames to stretch are picked by the carry out of a small phase accumulator that is advanced once per frame. Because each frame keeps a single rise and a single fall, a fixed difference between rise and fall times only shifts the output by a constant, and the transfer stays monotonic.

The command is copied into a shadow register only on the last clock of a frame, so the software loop may change it at any time. A final flop on the same clock retimes the waveform. A one-cycle frame-start strobe marks the cycle in which each frame's rising edge appears at the output.

Top module: `pwm_tune_dac`

## Requirements
- R1: A frame lasts exactly 2^CNT_WIDTH clocks. frameStart is high for one cycle at the start of every frame and low in all other cycles.
- R2: The number of high cycles of pwmOut in a frame is either hi or hi+1, where hi is cmd[CNT_WIDTH+LSB_WIDTH-1:LSB_WIDTH].
- R3: When hi is 0 and the frame is not stretched, pwmOut stays low for the whole frame.
- R4: When hi is all ones and the frame is stretched, pwmOut stays high for the whole frame, with no edge inside it.
- R5: When cmd is held constant, any 2^LSB_WIDTH consecutive frames contain exactly lo stretched frames (frames with hi+1 high cycles), where lo is cmd[LSB_WIDTH-1:0].
- R6: Within a frame, the high cycles of pwmOut form one contiguous run that starts in the cycle where frameStart is high. pwmOut therefore rises only in a frameStart cycle and falls at most once per frame.
- R7: cmd is sampled only on the clock edge that ends a frame, and its value governs the frame that follows. A change that is reverted before that edge has no effect. A change that is still present at that edge takes effect in the next frame.
- R8: rst is synchronous and active high. While it is asserted and after it is released, pwmOut is low. The first frame after release is entirely low whatever cmd holds. frameStart first goes high on the second clock edge after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock; every register uses its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | CNT_WIDTH+LSB_WIDTH | Tuning word: coarse high time in the upper bits, fractional stretch in the lower bits |
| pwmOut | output | 1 | Retimed single-bit PWM waveform |
| frameStart | output | 1 | One-cycle strobe aligned with the first cycle of each output frame |

## Verification
A wrong counter or wrap shows at once as a frameStart spacing other than one frame. A wrong threshold or a wrong comparison shows within a single frame, as a high-cycle count outside {hi, hi+1} or as a high run that does not start at frameStart. Faults in the accumulator or the stretch selection show only in aggregate. They need a full window of 2^LSB_WIDTH frames, over which the number of stretched frames must equal lo. A shadow register that samples cmd at the wrong time shows one frame after a mid-frame change to cmd.

// File: rtl/pwm_dac_pkg.sv
package pwm_dac_pkg;

  // Strobes from the frame control to the datapath
  typedef struct packed {
    logic wrap;   // last clock of the frame: load new command
    logic first;  // counter at zero: first clock of the frame
  } frameStrb_t;

endpackage

// File: rtl/pwm_frame_ctrl.sv
module pwm_frame_ctrl
  import pwm_dac_pkg::*;
#(
  parameter int CNT_WIDTH = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic [CNT_WIDTH-1:0] count,
  output frameStrb_t           strb
);

  localparam logic [CNT_WIDTH-1:0] LAST = '1;

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count + 1'b1;
  end

  assign strb.wrap  = (count == LAST);
  assign strb.first = (count == '0);

  // R1: the frame closes after its last count and restarts at zero
  p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    strb.wrap |=> strb.first);

  // R1: zero is never reached except after the last count
  p_no_early_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    !strb.wrap |=> !strb.first);

endmodule

// File: rtl/pwm_dither_dp.sv
module pwm_dither_dp
  import pwm_dac_pkg::*;
#(
  parameter int CNT_WIDTH = 10,
  parameter int LSB_WIDTH = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [CNT_WIDTH+LSB_WIDTH-1:0] cmd,
  input  logic [CNT_WIDTH-1:0]           count,
  input  frameStrb_t                     strb,
  output logic                           pwmLevel,
  output logic                           firstLate
);

  localparam int CMD_W = CNT_WIDTH + LSB_WIDTH;

  logic [CNT_WIDTH-1:0] shadowHi;
  logic [LSB_WIDTH-1:0] accum;
  logic                 extend;
  logic [LSB_WIDTH:0]   accSum;
  logic [CNT_WIDTH:0]   threshold;

  // The phase accumulator advances by the fractional part once per frame
  assign accSum = {1'b0, accum} + {1'b0, cmd[LSB_WIDTH-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      shadowHi <= '0;
      accum    <= '0;
      extend   <= 1'b0;
    end else if (strb.wrap) begin
      shadowHi <= cmd[CMD_W-1:LSB_WIDTH];
      accum    <= accSum[LSB_WIDTH-1:0];
      extend   <= accSum[LSB_WIDTH];
    end
  end

  // The pulse stays high while the count is below hi + stretch
  assign threshold = {1'b0, shadowHi} + {{CNT_WIDTH{1'b0}}, extend};

  always_ff @(posedge clk) begin
    if (rst) begin
      pwmLevel  <= 1'b0;
      firstLate <= 1'b0;
    end else begin
      pwmLevel  <= ({1'b0, count} < threshold);
      firstLate <= strb.first;
    end
  end

  // R7: the frame settings change only on the frame-closing edge
  p_shadow_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !strb.wrap |=> ($stable(shadowHi) && $stable(accum) && $stable(extend)));

  // R3: zero width and no stretch keep the pulse low
  p_empty_frame_r3: assert property (@(posedge clk) disable iff (rst)
    (shadowHi == '0 && !extend) |=> !pwmLevel);

  // R4: full width plus stretch keeps the pulse high
  p_full_frame_r4: assert property (@(posedge clk) disable iff (rst)
    (shadowHi == '1 && extend) |=> pwmLevel);

  // R6: the pulse can rise only from the frame's first count
  p_rise_at_start_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(pwmLevel) |-> $past(strb.first));

endmodule

// File: rtl/pwm_tune_dac.sv
module pwm_tune_dac
  import pwm_dac_pkg::*;
#(
  parameter int CNT_WIDTH = 10,
  parameter int LSB_WIDTH = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [CNT_WIDTH+LSB_WIDTH-1:0] cmd,
  output logic                           pwmOut,
  output logic                           frameStart
);

  logic [CNT_WIDTH-1:0] count;
  frameStrb_t           strb;
  logic                 pwmLevel;
  logic                 firstLate;

  pwm_frame_ctrl #(.CNT_WIDTH(CNT_WIDTH)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .count (count),
    .strb  (strb)
  );

  pwm_dither_dp #(.CNT_WIDTH(CNT_WIDTH), .LSB_WIDTH(LSB_WIDTH)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd),
    .count     (count),
    .strb      (strb),
    .pwmLevel  (pwmLevel),
    .firstLate (firstLate)
  );

  // Retiming flop: the output moves only on clock edges
  always_ff @(posedge clk) begin
    if (rst) begin
      pwmOut     <= 1'b0;
      frameStart <= 1'b0;
    end else begin
      pwmOut     <= pwmLevel;
      frameStart <= firstLate;
    end
  end

  // R6: an output rising edge is always marked by the frame strobe
  p_out_rise_aligned_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(pwmOut) |-> frameStart);

  // R8: the output stays low during reset
  p_reset_low_r8: assert property (@(posedge clk)
    rst |=> !pwmOut);

endmodule

// File: tb/tb_pwm_tune_dac.sv
module tb_pwm_tune_dac;

  localparam int CW    = 4;
  localparam int LW    = 3;
  localparam int CMDW  = CW + LW;
  localparam int FRAME = 1 << CW;
  localparam int WIN   = 1 << LW;
  localparam int HMAX  = FRAME - 1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [CMDW-1:0] cmd = '1;
  logic            pwmOut;
  logic            frameStart;

  int compared   = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  pwm_tune_dac #(.CNT_WIDTH(CW), .LSB_WIDTH(LW)) dut (
    .clk        (clk),
    .rst        (rst),
    .cmd        (cmd),
    .pwmOut     (pwmOut),
    .frameStart (frameStart)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [CMDW-1:0] mkCmd(input int hi, input int lo);
    return CMDW'((hi << LW) | lo);
  endfunction

  // Called at a negedge where frameStart is high; returns at the next one.
  // With tamper set, cmd becomes alt at offset 4 and, if revert is set,
  // goes back to its old value at offset 8 (both before the frame-closing edge).
  task automatic runFrame(output int highCnt, input bit tamper, input bit revert,
                          input logic [CMDW-1:0] alt);
    logic [FRAME-1:0] seen;
    logic [FRAME-1:0] shape;
    logic [CMDW-1:0]  saved;
    bit               early;
    saved   = cmd;
    seen    = '0;
    highCnt = 0;
    early   = 1'b0;
    for (int i = 0; i < FRAME; i++) begin
      if (i > 0 && frameStart) early = 1'b1;
      seen[i] = pwmOut;
      if (pwmOut) highCnt++;
      if (tamper && i == 4) cmd = alt;
      if (tamper && revert && i == 8) cmd = saved;
      @(negedge clk);
    end
    check(!early && frameStart, "R1", "frame strobe spacing", int'(frameStart), 1);
    shape = '0;
    for (int i = 0; i < FRAME; i++) shape[i] = (i < highCnt);
    check(seen == shape, "R6", "contiguous run from frame start", int'(seen), int'(shape));
  endtask

  initial begin
    int h;
    int stretched;
    int fullCnt;
    // Reset with a non-zero command: R8
    repeat (5) @(negedge clk);
    check(pwmOut == 1'b0, "R8", "pwmOut during reset", int'(pwmOut), 0);
    rst = 1'b0;
    check(pwmOut == 1'b0, "R8", "pwmOut at release", int'(pwmOut), 0);
    @(negedge clk);
    check(frameStart == 1'b0 && pwmOut == 1'b0, "R8", "first edge after release",
          int'(frameStart), 0);
    @(negedge clk);
    check(frameStart == 1'b1, "R8", "frameStart on second edge", int'(frameStart), 1);
    runFrame(h, 1'b0, 1'b0, '0);
    check(h == 0, "R8", "first frame high cycles", h, 0);

    // Sweep of every command value: R2, R3, R4, R5
    for (int hi = 0; hi <= HMAX; hi++) begin
      for (int lo = 0; lo < WIN; lo++) begin
        cmd = mkCmd(hi, lo);
        runFrame(h, 1'b0, 1'b0, '0);  // frame fixed before the change
        stretched = 0;
        fullCnt   = 0;
        for (int f = 0; f < WIN; f++) begin
          runFrame(h, 1'b0, 1'b0, '0);
          check(h == hi || h == hi + 1, "R2", "high cycles per frame", h, hi);
          if (h == hi + 1) stretched++;
          if (h == FRAME) fullCnt++;
          if (hi == 0 && lo == 0)
            check(h == 0, "R3", "empty frame", h, 0);
        end
        check(stretched == lo, "R5", "stretched frames in window", stretched, lo);
        if (hi == HMAX)
          check(fullCnt == lo, "R4", "fully high frames", fullCnt, lo);
      end
    end

    // Mid-frame change that is reverted: R7
    cmd = mkCmd(5, 0);
    runFrame(h, 1'b0, 1'b0, '0);
    runFrame(h, 1'b0, 1'b0, '0);
    check(h == 5, "R7", "baseline width", h, 5);
    runFrame(h, 1'b1, 1'b1, mkCmd(12, 7));
    check(h == 5, "R7", "frame during reverted change", h, 5);
    runFrame(h, 1'b0, 1'b0, '0);
    check(h == 5, "R7", "frame after reverted change", h, 5);
    // Mid-frame change that persists takes effect one frame later
    runFrame(h, 1'b1, 1'b0, mkCmd(12, 0));
    check(h == 5, "R7", "frame containing change", h, 5);
    runFrame(h, 1'b0, 1'b0, '0);
    check(h == 12, "R7", "frame after kept change", h, 12);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(4 * 150000);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule